// File: doc/BRIEF.md
# Programmable Integer Clock Divider

This block turns a fast input clock into a slower conversion clock by dividing it by any integer from 1 to 8. The divided clock comes out as a flop-driven level that is glitch-free and stays in step with the input clock. A one-cycle tick marks the first input cycle of each divided period, so logic that runs on the input clock can use it as a clock enable. A ratio code of 3 bits selects the division: the code is the ratio minus one. For an odd ratio the high part of the period is one input cycle longer than the low part. A separate flag reports that the duty is uneven, so that a downstream stabiliser can correct it.

Software writes a new ratio and a phase offset through a register interface and then pulses a load strobe. The new pair is held as pending and takes effect only at the end of a divided period, so the output never shows a truncated pulse. When a new setting is applied, the phase offset, reduced modulo the new ratio, holds the output low for that many input cycles before the first new period begins. This moves the starting edge of the divided clock in steps of one input cycle. A stabiliser-enable output is high whenever the active ratio is not 1.

Top module: `int_clk_divider`

## Requirements
- R1: After reset the active ratio is 1 (code 000), nothing is pending, `div_clk_o` and `div_tick_o` are high every cycle, and `dcs_en_o` and `odd_duty_o` are low.
- R2: With active code c and no pending change, `div_tick_o` is high exactly once every c+1 input cycles, in the first cycle of each divided period.
- R3: Within each divided period of ratio N, `div_clk_o` is high for the first (N+1)/2 cycles (integer division) and low for the rest. For ratio 1 it stays high.
- R4: `dcs_en_o` is high exactly when the active ratio code is not 000.
- R5: `odd_duty_o` is high exactly when the active ratio is odd and at least 3, which means the code is non-zero and its bit 0 is 0.
- R6: A strobe on `cfg_load_i` captures `cfg_ratio_i` and `cfg_phase_i` as pending. The pending pair becomes active on the clock edge that ends the current divided period. A strobe given in the last cycle of a period waits for the end of the following period.
- R7: When a pending pair becomes active with phase p and ratio N, `div_clk_o` and `div_tick_o` stay low for (p mod N) input cycles. The new period then begins, with its tick.
- R8: If a second strobe comes before the pending pair is applied, the later values replace the earlier ones.
- R9: Values on `cfg_ratio_i` and `cfg_phase_i` while `cfg_load_i` is low have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_ratio_i | input | 3 | Ratio code, ratio minus one |
| cfg_phase_i | input | 3 | Start-edge offset in input cycles |
| cfg_load_i | input | 1 | Strobe that captures ratio and phase as pending |
| div_clk_o | output | 1 | Divided clock level, flop-driven |
| div_tick_o | output | 1 | High in the first input cycle of each divided period |
| dcs_en_o | output | 1 | Duty-cycle stabiliser enable |
| odd_duty_o | output | 1 | High while the active ratio gives an uneven duty |

## Verification
A wrong period counter shows up within one divided period, at most eight input cycles, as a tick at the wrong place or a high phase of the wrong length. A pending setting that is lost or applied at the wrong time leaves the period, the stabiliser enable or the uneven-duty flag wrong from the edge where the change should have happened. A wrong phase remainder shows as a low gap before the first new tick that is too long or too short. Because the bench compares all four outputs in every cycle against a model built from the requirements, each of these faults shows up in the cycle where it first affects the outputs.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  parameter int unsigned CODE_W = 3;
  localparam int unsigned MAX_RATIO = 1 << CODE_W;

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    code_t ratio;
    code_t phase;
  } cfg_t;

  // phase mod (code+1) by bounded repeated subtraction
  function automatic code_t wrap_phase(code_t phase, code_t code);
    int unsigned r;
    int unsigned n;
    r = int'(phase);
    n = int'(code) + 1;
    for (int i = 0; i < MAX_RATIO; i++) begin
      if (r >= n) r = r - n;
    end
    return code_t'(r);
  endfunction

  // high length of a period: ceil(ratio/2) = (code+2)/2
  function automatic logic [CODE_W:0] high_len(code_t code);
    logic [CODE_W:0] t;
    t = {1'b0, code} + 2;
    return t >> 1;
  endfunction
endpackage

// File: rtl/clkdiv_cfg_stage.sv
module clkdiv_cfg_stage
  import clkdiv_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  code_t ratio_i,
  input  code_t phase_i,
  input  logic  load_i,
  input  logic  taken_i,
  output logic  pend_o,
  output cfg_t  pend_cfg_o
);
  logic pend_q;
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cfg_q  <= '0;
    end else begin
      if (load_i) begin
        pend_q      <= 1'b1;
        cfg_q.ratio <= ratio_i;
        cfg_q.phase <= phase_i;
      end else if (taken_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign pend_o     = pend_q;
  assign pend_cfg_o = cfg_q;

  a_r6_pend_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> pend_q);
  a_r8_latest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cfg_q.ratio == $past(ratio_i)) && (cfg_q.phase == $past(phase_i)));
  a_r9_hold_without_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_q));
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pend_i,
  input  cfg_t  pend_cfg_i,
  output logic  taken_o,
  output code_t ratio_d_o,
  output code_t cnt_d_o,
  output code_t hold_d_o
);
  code_t ratio_q, cnt_q, hold_q;
  code_t ratio_d, cnt_d, hold_d;
  logic  last_cyc;
  logic  apply;

  always_comb begin
    last_cyc = (hold_q == '0) && (cnt_q == ratio_q);
    apply    = last_cyc && pend_i;
    ratio_d  = ratio_q;
    cnt_d    = cnt_q;
    hold_d   = hold_q;
    if (apply) begin
      ratio_d = pend_cfg_i.ratio;
      hold_d  = wrap_phase(pend_cfg_i.phase, pend_cfg_i.ratio);
      cnt_d   = '0;
    end else if (hold_q != '0) begin
      hold_d = hold_q - 1'b1;
    end else if (last_cyc) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= '0;
      cnt_q   <= '0;
      hold_q  <= '0;
    end else begin
      ratio_q <= ratio_d;
      cnt_q   <= cnt_d;
      hold_q  <= hold_d;
    end
  end

  assign taken_o   = apply;
  assign ratio_d_o = ratio_d;
  assign cnt_d_o   = cnt_d;
  assign hold_d_o  = hold_d;

  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= ratio_q);
  a_r6_ratio_only_on_apply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply |=> $stable(ratio_q));
  a_r7_gap_parks_counter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q != '0) |-> (cnt_q == '0));
  a_r7_gap_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hold_q != '0) && !apply) |=> (hold_q == $past(hold_q) - 1'b1));
endmodule

// File: rtl/clkdiv_wave.sv
module clkdiv_wave
  import clkdiv_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  code_t ratio_d_i,
  input  code_t cnt_d_i,
  input  code_t hold_d_i,
  output logic  div_clk_o,
  output logic  tick_o,
  output logic  dcs_en_o,
  output logic  odd_o
);
  logic run_d;
  logic clk_q, tick_q, dcs_q, odd_q;

  assign run_d = (hold_d_i == '0);

  // decoded from next state so the outputs are plain flops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q  <= 1'b1;
      tick_q <= 1'b1;
      dcs_q  <= 1'b0;
      odd_q  <= 1'b0;
    end else begin
      clk_q  <= run_d && ({1'b0, cnt_d_i} < high_len(ratio_d_i));
      tick_q <= run_d && (cnt_d_i == '0);
      dcs_q  <= (ratio_d_i != '0);
      odd_q  <= (ratio_d_i != '0) && !ratio_d_i[0];
    end
  end

  assign div_clk_o = clk_q;
  assign tick_o    = tick_q;
  assign dcs_en_o  = dcs_q;
  assign odd_o     = odd_q;

  a_r3_tick_starts_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> clk_q);
  a_r2_no_back_to_back_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_q && dcs_q) |=> !tick_q);
  a_r5_odd_implies_dcs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odd_q |-> dcs_q);
  a_r4_div1_always_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dcs_q && $past(!dcs_q)) |-> clk_q);
endmodule

// File: rtl/int_clk_divider.sv
module int_clk_divider
  import clkdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] cfg_ratio_i,
  input  logic [CODE_W-1:0] cfg_phase_i,
  input  logic              cfg_load_i,
  output logic              div_clk_o,
  output logic              div_tick_o,
  output logic              dcs_en_o,
  output logic              odd_duty_o
);
  logic  pend;
  cfg_t  pend_cfg;
  logic  taken;
  code_t ratio_d, cnt_d, hold_d;

  clkdiv_cfg_stage u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ratio_i    (cfg_ratio_i),
    .phase_i    (cfg_phase_i),
    .load_i     (cfg_load_i),
    .taken_i    (taken),
    .pend_o     (pend),
    .pend_cfg_o (pend_cfg)
  );

  clkdiv_counter u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (pend),
    .pend_cfg_i (pend_cfg),
    .taken_o    (taken),
    .ratio_d_o  (ratio_d),
    .cnt_d_o    (cnt_d),
    .hold_d_o   (hold_d)
  );

  clkdiv_wave u_wave (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ratio_d_i (ratio_d),
    .cnt_d_i   (cnt_d),
    .hold_d_i  (hold_d),
    .div_clk_o (div_clk_o),
    .tick_o    (div_tick_o),
    .dcs_en_o  (dcs_en_o),
    .odd_o     (odd_duty_o)
  );

  a_r6_apply_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken |-> pend);
endmodule

// File: tb/int_clk_divider_test.sv
module int_clk_divider_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cfg_ratio_i = '0;
  logic [2:0] cfg_phase_i = '0;
  logic       cfg_load_i = 1'b0;
  logic       div_clk_o, div_tick_o, dcs_en_o, odd_duty_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model, in ratio / position / gap terms
  int m_ratio, m_pos, m_gap, m_pr, m_pp;
  bit m_pend;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int_clk_divider uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_ratio_i (cfg_ratio_i),
    .cfg_phase_i (cfg_phase_i),
    .cfg_load_i  (cfg_load_i),
    .div_clk_o   (div_clk_o),
    .div_tick_o  (div_tick_o),
    .dcs_en_o    (dcs_en_o),
    .odd_duty_o  (odd_duty_o)
  );

  function automatic bit exp_clk();
    return (m_gap == 0) && (m_pos < (m_ratio + 1) / 2);
  endfunction
  function automatic bit exp_tick();
    return (m_gap == 0) && (m_pos == 0);
  endfunction
  function automatic bit exp_dcs();
    return m_ratio != 1;
  endfunction
  function automatic bit exp_odd();
    return (m_ratio % 2 == 1) && (m_ratio >= 3);
  endfunction

  task automatic model_edge(bit ld, int r, int p);
    bit fin;
    fin = (m_gap == 0) && (m_pos == m_ratio - 1);
    if (fin && m_pend) begin
      m_ratio = m_pr + 1;
      m_gap   = m_pp % m_ratio;
      m_pos   = 0;
      m_pend  = 0;
    end else if (m_gap > 0) begin
      m_gap = m_gap - 1;
    end else begin
      m_pos = (m_pos + 1) % m_ratio;
    end
    if (ld) begin
      m_pend = 1;
      m_pr   = r;
      m_pp   = p;
    end
  endtask

  task automatic check_bit(string tag, string nm, bit act, bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b (ratio=%0d pos=%0d gap=%0d) t=%0t",
               tag, nm, act, exp, m_ratio, m_pos, m_gap, $time);
    end
  endtask

  task automatic check_all(string ctx);
    check_bit({ctx, "/R3"}, "div_clk_o", div_clk_o, exp_clk());
    check_bit({ctx, "/R2"}, "div_tick_o", div_tick_o, exp_tick());
    check_bit({ctx, "/R4"}, "dcs_en_o", dcs_en_o, exp_dcs());
    check_bit({ctx, "/R5"}, "odd_duty_o", odd_duty_o, exp_odd());
  endtask

  // called just after a negedge; drives, clocks, updates model, checks
  task automatic step(string ctx, bit ld, int r, int p);
    cfg_load_i  = ld;
    cfg_ratio_i = 3'(r);
    cfg_phase_i = 3'(p);
    @(posedge clk_i);
    model_edge(ld, r, p);
    @(negedge clk_i);
    check_all(ctx);
  endtask

  task automatic idle(string ctx, int cycles, int r, int p);
    for (int i = 0; i < cycles; i++) step(ctx, 1'b0, r, p);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd24681));
    m_ratio = 1; m_pos = 0; m_gap = 0; m_pend = 0; m_pr = 0; m_pp = 0;
    repeat (3) @(negedge clk_i);
    check_all("R1");
    rst_ni = 1'b1;
    idle("R1", 4, 0, 0);

    // every ratio, phase 0
    for (int c = 0; c < 8; c++) begin
      step("R6", 1'b1, c, 0);
      idle("R2", 3 * (c + 1) + 10, c, 0);
    end

    // phase wrap: ratio 3, phase 7 -> gap of 1
    step("R7", 1'b1, 2, 7);
    idle("R7", 14, 2, 7);
    // ratio 8, phase 5
    step("R7", 1'b1, 7, 5);
    idle("R7", 30, 7, 5);
    // ratio 6, phase 6 -> wraps to 0
    step("R7", 1'b1, 5, 6);
    idle("R7", 20, 5, 6);

    // two strobes before application, later wins
    step("R8", 1'b1, 6, 0);
    step("R8", 1'b1, 3, 2);
    idle("R8", 24, 3, 2);

    // inputs wiggling without a strobe
    for (int i = 0; i < 40; i++) step("R9", 1'b0, $urandom % 8, $urandom % 8);

    // strobe exactly in the last cycle of a period (ratio 4 active)
    while (!(div_tick_o)) step("R6", 1'b0, 0, 0);
    idle("R6", 3, 0, 0);
    step("R6", 1'b1, 1, 0);
    idle("R6", 12, 1, 0);

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      bit ld;
      ld = ($urandom % 16) == 0;
      step("R6", ld, $urandom % 8, $urandom % 8);
    end

    finish_run();
  end
endmodule